// File: doc/BRIEF.md
# Mailbox Register Access Bridge

This block lets a host reach a small peripheral register file without decoding that file on the host bus. The host sees only two byte-wide ports. The pointer port at offset 0 selects a byte in a shared mailbox memory. The data port at offset 1 reads or writes the selected byte. To issue an access, the host fills a register-number slot and a data slot, then writes a request code into a command byte. The bridge picks up the request, performs it on the register file, places any read result in the data slot, and clears the command byte to show that the access is complete.

The same memory also carries information that flows from the peripheral side. One byte mirrors an interrupt identification input. Another byte reports how many received bytes have been captured. A window of bytes above those holds the received bytes in arrival order, so the host can collect them with plain memory reads.

Top module: `mbx_bridge`

## Requirements
- R1: After reset, the pointer port reads 0x00, the command byte reads 0x00 and the receive status byte at 0x1F reads 0x00.
- R2: A write at offset 0 sets the mailbox pointer. Only the low 6 bits are kept, and offset 0 reads back the pointer. Offset 1 reads the byte at the pointer without delay, and a write at offset 1 stores the byte at the pointer.
- R3: The command byte is at 0x1A, the register-number slot at 0x1B and the data slot at 0x1C. Command code 0x01 writes the data slot into the register that the register-number slot selects.
- R4: Command code 0x02 copies the selected register into the data slot. The copy is in place by the time the command byte reads 0x00.
- R5: Any nonzero command byte still reads nonzero one clock edge after the edge that wrote it. It reads 0x00 after the second edge.
- R6: A nonzero command code other than 0x01 or 0x02 is cleared with the same timing. It touches no register and leaves the data slot unchanged.
- R7: A request uses the slot contents present at the first edge after the command write. Slot writes made at or after the completing edge do not change that request.
- R8: When a host write to the command byte lands on the same edge as the bridge's completion clear, the clear wins and no new request starts.
- R9: A register number at or above the register count (16) is ignored on a write and returns 0x00 on a read. It does not alias onto a lower register.
- R10: Byte 0x1E follows the interrupt identification input one clock later. Host writes to byte 0x1E have no lasting effect.
- R11: Each receive push stores its byte at 0x20 plus the current count, then increments the count. The count is reported in bits 5:0 of byte 0x1F.
- R12: A push made while the count equals the capture depth (32) is dropped and leaves the stored bytes unchanged. It sets bit 7 of byte 0x1F.
- R13: A host write of any value to byte 0x1F clears the count and the overflow bit, so the next push lands at 0x20 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_addr | input | 1 | Host port select: 0 pointer, 1 data |
| host_wr | input | 1 | Host write strobe for one cycle |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Pointer (offset 0) or mailbox byte at the pointer (offset 1) |
| irq_id_in | input | 8 | Interrupt identification value to mirror |
| rx_push | input | 1 | Receive byte strobe |
| rx_byte | input | 8 | Received byte |

## Verification
Host writes take effect at the edge that samples the strobe, and offset 1 reads are combinational, so the bench samples a pointer or data write just after the next falling edge. A request samples the command byte at the first edge after it is written, and the bench checks that it is still nonzero there. The bench then checks that it reads zero after the second edge, and the read result is already present in the data slot at that point. The interrupt mirror and receive captures each land one edge after their inputs, and the bench checks both the stale value before that edge and the new value after it.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam int BYTE_W = 8;

  // Mailbox layout; offsets are part of the host-visible contract
  localparam int OFF_CMD  = 'h1A;
  localparam int OFF_RIDX = 'h1B;
  localparam int OFF_DATA = 'h1C;
  localparam int OFF_IRQ  = 'h1E;
  localparam int OFF_STAT = 'h1F;
  localparam int OFF_RXW  = 'h20;

  typedef enum logic [BYTE_W-1:0] {
    CMD_IDLE  = 8'h00,
    CMD_WRITE = 8'h01,
    CMD_READ  = 8'h02
  } cmd_e;

  typedef enum logic {
    ST_WAIT = 1'b0,
    ST_EXEC = 1'b1
  } seq_state_e;

endpackage

// File: rtl/mbx_host_port.sv
module mbx_host_port
  import mbx_pkg::*;
#(
  parameter int MEM_DEPTH = 64,
  localparam int MEM_AW   = $clog2(MEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_addr,
  input  logic              host_wr,
  input  logic [BYTE_W-1:0] host_wdata,
  input  logic [BYTE_W-1:0] mem_rd_data,
  output logic [MEM_AW-1:0] ptr,
  output logic              mem_we,
  output logic [BYTE_W-1:0] host_rdata
);

  logic [MEM_AW-1:0] ptr_q, ptr_d;
  logic              ptr_ce;

  always_comb begin
    ptr_ce = host_wr && !host_addr;
    ptr_d  = host_wdata[MEM_AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_ce) ptr_q <= ptr_d;
  end

  assign ptr    = ptr_q;
  assign mem_we = host_wr && host_addr;

  always_comb begin
    if (host_addr) host_rdata = mem_rd_data;
    else           host_rdata = BYTE_W'(ptr_q);
  end

endmodule

// File: rtl/mbx_store.sv
module mbx_store
  import mbx_pkg::*;
#(
  parameter int RX_DEPTH   = 32,
  localparam int MEM_DEPTH = OFF_RXW + RX_DEPTH,
  localparam int MEM_AW    = $clog2(MEM_DEPTH),
  localparam int CNT_W     = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [MEM_AW-1:0] host_idx,
  input  logic [BYTE_W-1:0] host_wdata,
  input  logic              val_load,
  input  logic [BYTE_W-1:0] val_data,
  input  logic              cmd_clr,
  input  logic [BYTE_W-1:0] irq_id_in,
  input  logic              rx_push,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] cmd_byte,
  output logic [BYTE_W-1:0] ridx_byte,
  output logic [BYTE_W-1:0] data_byte,
  output logic [BYTE_W-1:0] rx_status
);

  logic [BYTE_W-1:0] bytes_w [MEM_DEPTH];

  // Receive capture count and overflow flag
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             drain, push_ok;

  always_comb begin
    drain   = host_we && (host_idx == MEM_AW'(OFF_STAT));
    push_ok = rx_push && !drain && (cnt_q < CNT_W'(RX_DEPTH));
    cnt_d   = cnt_q;
    ovf_d   = ovf_q;
    if (drain) begin
      cnt_d = '0;
      ovf_d = 1'b0;
    end else if (rx_push) begin
      if (push_ok) cnt_d = cnt_q + 1'b1;
      else         ovf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  always_comb begin
    rx_status = '0;
    rx_status[CNT_W-1:0] = cnt_q;
    rx_status[BYTE_W-1]  = ovf_q;
  end

  for (genvar i = 0; i < MEM_DEPTH; i++) begin : g_byte
    if (i == OFF_STAT) begin : g_stat
      assign bytes_w[i] = rx_status;
    end else begin : g_cell
      logic [BYTE_W-1:0] q, d;
      logic              ce, host_hit;

      always_comb begin
        host_hit = host_we && (host_idx == MEM_AW'(i));
        ce = host_hit;
        d  = host_wdata;
        if (i == OFF_IRQ) begin
          ce = 1'b1;
          d  = irq_id_in;
        end else if (i == OFF_CMD) begin
          if (cmd_clr) begin
            ce = 1'b1;
            d  = '0;
          end
        end else if (i == OFF_DATA) begin
          if (val_load) begin
            ce = 1'b1;
            d  = val_data;
          end
        end else if (i >= OFF_RXW) begin
          if (push_ok && (cnt_q == CNT_W'(i - OFF_RXW))) begin
            ce = 1'b1;
            d  = rx_byte;
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (ce) q <= d;
      end

      assign bytes_w[i] = q;
    end
  end

  always_comb begin
    if (32'(host_idx) < MEM_DEPTH) rd_data = bytes_w[host_idx];
    else                           rd_data = '0;
  end

  assign cmd_byte  = bytes_w[OFF_CMD];
  assign ridx_byte = bytes_w[OFF_RIDX];
  assign data_byte = bytes_w[OFF_DATA];

endmodule

// File: rtl/mbx_seq.sv
module mbx_seq
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] cmd_byte,
  input  logic [BYTE_W-1:0] ridx_byte,
  input  logic [BYTE_W-1:0] data_byte,
  output logic              reg_we,
  output logic [BYTE_W-1:0] reg_idx,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              val_load,
  output logic              cmd_clr
);

  seq_state_e        state_q, state_d;
  logic [BYTE_W-1:0] cmd_q, ridx_q, data_q;
  logic              cap_ce;

  always_comb begin
    state_d = state_q;
    cap_ce  = 1'b0;
    case (state_q)
      ST_WAIT: begin
        if (cmd_byte != CMD_IDLE) begin
          state_d = ST_EXEC;
          cap_ce  = 1'b1;
        end
      end
      ST_EXEC: state_d = ST_WAIT;
      default: state_d = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_WAIT;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      ridx_q <= '0;
      data_q <= '0;
    end else if (cap_ce) begin
      cmd_q  <= cmd_byte;
      ridx_q <= ridx_byte;
      data_q <= data_byte;
    end
  end

  always_comb begin
    cmd_clr   = (state_q == ST_EXEC);
    reg_we    = cmd_clr && (cmd_q == CMD_WRITE);
    val_load  = cmd_clr && (cmd_q == CMD_READ);
    reg_idx   = ridx_q;
    reg_wdata = data_q;
  end

endmodule

// File: rtl/mbx_regfile.sv
module mbx_regfile
  import mbx_pkg::*;
#(
  parameter int REG_COUNT = 16,
  localparam int RIDX_W   = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [BYTE_W-1:0] idx,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata
);

  logic [BYTE_W-1:0] regs_w [REG_COUNT];
  logic              in_range;

  assign in_range = (32'(idx) < REG_COUNT);

  for (genvar r = 0; r < REG_COUNT; r++) begin : g_reg
    logic [BYTE_W-1:0] q;
    logic              ce;

    assign ce = we && in_range && (idx[RIDX_W-1:0] == RIDX_W'(r));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (ce) q <= wdata;
    end

    assign regs_w[r] = q;
  end

  always_comb begin
    if (in_range) rdata = regs_w[idx[RIDX_W-1:0]];
    else          rdata = '0;
  end

endmodule

// File: rtl/mbx_bridge.sv
module mbx_bridge
  import mbx_pkg::*;
#(
  parameter int REG_COUNT = 16,
  parameter int RX_DEPTH  = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_addr,
  input  logic       host_wr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic [7:0] irq_id_in,
  input  logic       rx_push,
  input  logic [7:0] rx_byte
);

  localparam int MEM_DEPTH = OFF_RXW + RX_DEPTH;
  localparam int MEM_AW    = $clog2(MEM_DEPTH);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end

  assign rst_sync_n = rst_pipe_q[1];

  logic [MEM_AW-1:0] ptr;
  logic              mem_we;
  logic [7:0]        mem_rd_data;
  logic [7:0]        cmd_byte, ridx_byte, data_byte, rx_status;
  logic              reg_we, val_load, cmd_clr;
  logic [7:0]        reg_idx, reg_wdata, reg_rd_data;

  mbx_host_port #(.MEM_DEPTH(MEM_DEPTH)) u_port (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .host_addr   (host_addr),
    .host_wr     (host_wr),
    .host_wdata  (host_wdata),
    .mem_rd_data (mem_rd_data),
    .ptr         (ptr),
    .mem_we      (mem_we),
    .host_rdata  (host_rdata)
  );

  mbx_store #(.RX_DEPTH(RX_DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .host_we    (mem_we),
    .host_idx   (ptr),
    .host_wdata (host_wdata),
    .val_load   (val_load),
    .val_data   (reg_rd_data),
    .cmd_clr    (cmd_clr),
    .irq_id_in  (irq_id_in),
    .rx_push    (rx_push),
    .rx_byte    (rx_byte),
    .rd_data    (mem_rd_data),
    .cmd_byte   (cmd_byte),
    .ridx_byte  (ridx_byte),
    .data_byte  (data_byte),
    .rx_status  (rx_status)
  );

  mbx_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cmd_byte  (cmd_byte),
    .ridx_byte (ridx_byte),
    .data_byte (data_byte),
    .reg_we    (reg_we),
    .reg_idx   (reg_idx),
    .reg_wdata (reg_wdata),
    .val_load  (val_load),
    .cmd_clr   (cmd_clr)
  );

  mbx_regfile #(.REG_COUNT(REG_COUNT)) u_regs (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (reg_we),
    .idx   (reg_idx),
    .wdata (reg_wdata),
    .rdata (reg_rd_data)
  );

endmodule

// File: rtl/mbx_bridge_chk.sv
module mbx_bridge_chk #(
  parameter int RX_DEPTH = 32
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] cmd_byte,
  input logic [7:0] data_byte,
  input logic [7:0] reg_rd_data,
  input logic [7:0] rx_status,
  input logic       cmd_clr,
  input logic       val_load,
  input logic       reg_we
);

  AST_CMD_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clr |=> (cmd_byte == 8'h00)); // R5

  AST_REQ_PICKED_UP: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_byte != 8'h00) && !cmd_clr) |=> cmd_clr); // R5

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clr |=> !cmd_clr); // R8

  AST_WRITE_NEEDS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> ($past(cmd_byte) == 8'h01)); // R6

  AST_READ_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    val_load |=> (data_byte == $past(reg_rd_data))); // R4

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(rx_status[6:0]) <= RX_DEPTH)); // R11

  AST_OVF_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_status[7]) |-> (32'($past(rx_status[6:0])) == RX_DEPTH)); // R12

endmodule

bind mbx_bridge mbx_bridge_chk #(.RX_DEPTH(RX_DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .cmd_byte    (cmd_byte),
  .data_byte   (data_byte),
  .reg_rd_data (reg_rd_data),
  .rx_status   (rx_status),
  .cmd_clr     (cmd_clr),
  .val_load    (val_load),
  .reg_we      (reg_we)
);

// File: tb/mbx_bridge_bench.sv
`timescale 1ns/1ps
module mbx_bridge_bench;

  logic       clk;
  logic       rst_n;
  logic       host_addr;
  logic       host_wr;
  logic [7:0] host_wdata;
  logic [7:0] host_rdata;
  logic [7:0] irq_id_in;
  logic       rx_push;
  logic [7:0] rx_byte;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  mbx_bridge u_mbx_bridge (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .irq_id_in  (irq_id_in),
    .rx_push    (rx_push),
    .rx_byte    (rx_byte)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge
  task automatic wr(input logic a, input logic [7:0] d);
    host_addr  = a;
    host_wdata = d;
    host_wr    = 1'b1;
    @(negedge clk);
    host_wr    = 1'b0;
  endtask

  task automatic rd_byte(input logic [7:0] idx, output logic [7:0] val);
    wr(1'b0, idx);
    host_addr = 1'b1;
    #1 val = host_rdata;
  endtask

  task automatic request(input logic [7:0] code, input logic [7:0] ridx, input logic [7:0] dat);
    wr(1'b0, 8'h1B); wr(1'b1, ridx);
    wr(1'b0, 8'h1C); wr(1'b1, dat);
    wr(1'b0, 8'h1A); wr(1'b1, code);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic push(input logic [7:0] b);
    rx_push = 1'b1;
    rx_byte = b;
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    host_addr = 1'b0;
    #1 chk("R1", "pointer after reset", host_rdata, 8'h00);
    host_addr = 1'b1;
    #1 chk("R1", "byte 0x00 after reset", host_rdata, 8'h00);
    rd_byte(8'h1A, v); chk("R1", "command byte after reset", v, 8'h00);
    rd_byte(8'h1F, v); chk("R1", "status after reset", v, 8'h00);
  endtask

  task automatic t_ports;
    logic [7:0] v;
    wr(1'b0, 8'hC5);
    host_addr = 1'b0;
    #1 chk("R2", "pointer keeps low 6 bits", host_rdata, 8'h05);
    wr(1'b1, 8'h6B);
    rd_byte(8'h05, v); chk("R2", "scratch byte readback", v, 8'h6B);
    rd_byte(8'h06, v); chk("R2", "neighbour byte untouched", v, 8'h00);
  endtask

  task automatic t_write_read;
    logic [7:0] v;
    request(8'h01, 8'h03, 8'hA5);
    request(8'h01, 8'h0F, 8'hC3);
    request(8'h02, 8'h03, 8'h00);
    rd_byte(8'h1C, v); chk("R3", "write then R4 read of reg 3", v, 8'hA5);
    request(8'h02, 8'h0F, 8'h00);
    rd_byte(8'h1C, v); chk("R4", "read of last reg 15", v, 8'hC3);
    request(8'h02, 8'h00, 8'h99);
    rd_byte(8'h1C, v); chk("R4", "read of unwritten reg 0", v, 8'h00);
  endtask

  task automatic t_timing;
    wr(1'b0, 8'h1B); wr(1'b1, 8'h07);
    wr(1'b0, 8'h1A); wr(1'b1, 8'h01);
    #1 chk("R5", "command just after its write", host_rdata, 8'h01);
    @(negedge clk);
    #1 chk("R5", "command after first edge", host_rdata, 8'h01);
    @(negedge clk);
    #1 chk("R5", "command after second edge", host_rdata, 8'h00);
  endtask

  task automatic t_unknown;
    logic [7:0] v;
    request(8'h01, 8'h02, 8'h11);
    wr(1'b0, 8'h1B); wr(1'b1, 8'h02);
    wr(1'b0, 8'h1C); wr(1'b1, 8'h77);
    wr(1'b0, 8'h1A); wr(1'b1, 8'h09);
    @(negedge clk);
    #1 chk("R6", "unknown code after first edge", host_rdata, 8'h09);
    @(negedge clk);
    #1 chk("R6", "unknown code cleared", host_rdata, 8'h00);
    rd_byte(8'h1C, v); chk("R6", "data slot unchanged", v, 8'h77);
    request(8'h02, 8'h02, 8'h00);
    rd_byte(8'h1C, v); chk("R6", "register untouched", v, 8'h11);
  endtask

  task automatic t_capture;
    logic [7:0] v;
    wr(1'b0, 8'h1B); wr(1'b1, 8'h08);
    wr(1'b0, 8'h1C); wr(1'b1, 8'h5E);
    wr(1'b0, 8'h1A); wr(1'b1, 8'h01);
    wr(1'b0, 8'h1B);
    wr(1'b1, 8'h09);
    request(8'h02, 8'h08, 8'h00);
    rd_byte(8'h1C, v); chk("R7", "captured register number used", v, 8'h5E);
    request(8'h02, 8'h09, 8'h00);
    rd_byte(8'h1C, v); chk("R7", "late slot write not used", v, 8'h00);
  endtask

  task automatic t_race;
    wr(1'b0, 8'h1B); wr(1'b1, 8'h05);
    wr(1'b0, 8'h1C); wr(1'b1, 8'h3C);
    wr(1'b0, 8'h1A); wr(1'b1, 8'h01);
    @(negedge clk);
    wr(1'b1, 8'h02);
    #1 chk("R8", "clear beats host write", host_rdata, 8'h00);
    @(negedge clk);
    #1 chk("R8", "no new request one edge later", host_rdata, 8'h00);
    @(negedge clk);
    #1 chk("R8", "no new request two edges later", host_rdata, 8'h00);
  endtask

  task automatic t_range;
    logic [7:0] v;
    request(8'h01, 8'h14, 8'h4D);
    request(8'h02, 8'h14, 8'hFF);
    rd_byte(8'h1C, v); chk("R9", "out-of-range read is zero", v, 8'h00);
    request(8'h02, 8'h04, 8'hFF);
    rd_byte(8'h1C, v); chk("R9", "no alias onto reg 4", v, 8'h00);
  endtask

  task automatic t_irq;
    logic [7:0] v;
    rd_byte(8'h1E, v); chk("R10", "mirror idle value", v, 8'h00);
    irq_id_in = 8'h5A;
    #1 chk("R10", "mirror before edge", host_rdata, 8'h00);
    @(negedge clk);
    #1 chk("R10", "mirror after edge", host_rdata, 8'h5A);
    wr(1'b1, 8'hFF);
    #1 chk("R10", "host write has no effect", host_rdata, 8'h5A);
  endtask

  task automatic t_rx;
    logic [7:0] v;
    push(8'hD0); push(8'hD1); push(8'hD2);
    rd_byte(8'h1F, v); chk("R11", "count after three pushes", v, 8'h03);
    rd_byte(8'h20, v); chk("R11", "first byte", v, 8'hD0);
    rd_byte(8'h22, v); chk("R11", "third byte", v, 8'hD2);
    for (int k = 3; k < 32; k++) push(8'(8'h40 + k));
    rd_byte(8'h1F, v); chk("R12", "count at full", v, 8'h20);
    push(8'hEE);
    rd_byte(8'h1F, v); chk("R12", "overflow flag set", v, 8'hA0);
    rd_byte(8'h3F, v); chk("R12", "last stored byte kept", v, 8'h5F);
    rd_byte(8'h20, v); chk("R12", "first byte kept", v, 8'hD0);
    wr(1'b0, 8'h1F); wr(1'b1, 8'h3C);
    host_addr = 1'b1;
    #1 chk("R13", "status cleared", host_rdata, 8'h00);
    push(8'hB7);
    rd_byte(8'h20, v); chk("R13", "next push at base", v, 8'hB7);
    rd_byte(8'h1F, v); chk("R13", "count restarted", v, 8'h01);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n      = 1'b0;
    host_addr  = 1'b0;
    host_wr    = 1'b0;
    host_wdata = 8'h00;
    irq_id_in  = 8'h00;
    rx_push    = 1'b0;
    rx_byte    = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_ports();
    t_write_read();
    t_timing();
    t_unknown();
    t_capture();
    t_race();
    t_range();
    t_irq();
    t_rx();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule